// File: doc/BRIEF.md
# TDM Output Multiplexer with Delayed Address Pipeline

This block interleaves fifteen serial channel inputs and one overhead serial input into a single time-division multiplexed bit stream. A built-in address sequencer walks a 16-slot word, one slot per multiplexer clock. A minor frame is 32 words long. In every word, slot 0 belongs to the overhead input and slots 1 to 15 belong to channels 1 to 15 in ascending order. The overhead input is only granted its slot in words 1 through 28 of the minor frame. In the remaining words that slot carries a constant 0.

The address from the sequencer does not drive the selector directly. It first passes through a chain of three registers, so that the selection lines up with the latency of the data paths upstream. The selected bit is inverted and captured by the output reclocking stage. This stage drives a true serial output and a complementary serial output, both at the multiplexer clock rate. Channels that are disabled by the enable vector read as 0 whenever their slot comes up.

The sequencer is a two-state machine. SEQ_FILL is entered on reset and lasts while the address chain fills. After three clocks the FILL_DONE transition moves it to SEQ_RUN. SEQ_RUN then holds, through the RUN_HOLD transition, until the next reset. While the machine is in SEQ_FILL the selector is blanked, so the serial output reads 0.

Top module: `tdm_out_mux`

## Requirements
- R1: While reset is asserted, and after each of the first three clock edges following its release, `ser_out` is 0 and `ser_out_n` is 1.
- R2: Stream index i carries word i/16 and slot i%16. A slot s from 1 to 15 carries `chan_data[s-1]` when `chan_en[s-1]` is 1, so the channels follow slot 0 in ascending order within each word.
- R3: The address reaches the selector three clocks after the sequencer issues it, and the output stage adds one more register. As a result, the bit sampled at clock edge i+4 after reset release is stream index i. Index 0 appears after the fourth edge and index 1 after the fifth.
- R4: Slot 0 carries `oh_data` in words 1 through 28 of the 32-word minor frame, and a constant 0 in words 0, 29, 30 and 31.
- R5: A channel slot whose `chan_en` bit is 0 carries 0, whatever its `chan_data` bit holds.
- R6: Out of reset, `ser_out_n` is always the complement of `ser_out`.
- R7: After word 31 slot 15, the stream continues with word 0 slot 0. Stream index 512 is therefore identical in position to index 0, and the frames repeat without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplexer clock, one slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 15 | Per-channel enable; bit k-1 enables channel k |
| chan_data | input | 15 | Current serial bit of each channel; bit k-1 is channel k |
| oh_data | input | 1 | Current serial bit of the overhead input |
| ser_out | output | 1 | Multiplexed serial stream, true polarity |
| ser_out_n | output | 1 | Multiplexed serial stream, complementary polarity |

## Verification
The assertions check several properties on every cycle:
- The output pair stays complementary.
- A blanked selector yields 0 on the next clock.
- Slot 0 yields 0 outside the overhead window.
- A disabled channel yields 0.
- The slot counter wraps into the next word.
- The sequencer's live flag agrees with the valid bit at the end of the address chain.

The directed scenarios cover what a single-cycle property cannot see:
- the exact four-edge offset between reset release and the first stream bit;
- the ascending slot order under several data patterns;
- the full 32-word overhead window;
- the seamless wrap from one minor frame into the next.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;

    // Slot field: one bit position inside a word.
    localparam int SLOT_W      = 4;
    localparam int SLOTS       = 1 << SLOT_W;

    // Word field: one word inside a minor frame.
    localparam int WORD_W      = 5;
    localparam int FRAME_WORDS = 1 << WORD_W;

    localparam int ADDR_W      = WORD_W + SLOT_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SLOT_W-1:0] slot;
    } tdm_addr_t;

    typedef enum logic {
        SEQ_FILL = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/tdm_addr_seq.sv
module tdm_addr_seq
    import tdm_mux_pkg::*;
#(
    parameter int FILL_CYC = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    output tdm_addr_t addr,
    output logic      live
);

    localparam int CNT_W = (FILL_CYC > 1) ? $clog2(FILL_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_CYC - 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  fill_cnt_q;
    logic [ADDR_W-1:0] pos_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_FILL: if (fill_cnt_q == FILL_LAST) state_d = SEQ_RUN;  // FILL_DONE
            SEQ_RUN:  state_d = SEQ_RUN;                               // RUN_HOLD
            default:  state_d = SEQ_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_FILL;
        else        state_q <= state_d;
    end

    // Fill counter and slot position counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt_q <= '0;
            pos_q      <= '0;
        end else begin
            pos_q <= pos_q + ADDR_W'(1);
            if (state_q == SEQ_FILL)
                fill_cnt_q <= fill_cnt_q + CNT_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        addr = pos_q;
        live = (state_q == SEQ_RUN);
    end

    // R7: the last slot of a word hands over to slot 0 of the next word.
    p_word_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr.slot == SLOT_W'(SLOTS - 1)) |=>
            (addr.slot == '0) && (addr.word == $past(addr.word) + WORD_W'(1)));

    // R1: once running, the machine never falls back to filling.
    p_run_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> live);

endmodule

// File: rtl/tdm_addr_pipe.sv
module tdm_addr_pipe
    import tdm_mux_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tdm_addr_t addr_in,
    input  logic      vld_in,
    output tdm_addr_t addr_out,
    output logic      vld_out
);

    tdm_addr_t stg_addr [DEPTH];
    logic      stg_vld  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_addr[g] <= '0;
                    stg_vld[g]  <= 1'b0;
                end else begin
                    stg_addr[g] <= addr_in;
                    stg_vld[g]  <= vld_in;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_addr[g] <= '0;
                    stg_vld[g]  <= 1'b0;
                end else begin
                    stg_addr[g] <= stg_addr[g-1];
                    stg_vld[g]  <= stg_vld[g-1];
                end
            end
        end
    end

    assign addr_out = stg_addr[DEPTH-1];
    assign vld_out  = stg_vld[DEPTH-1];

endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel
    import tdm_mux_pkg::*;
#(
    parameter int N_CHAN   = 15,
    parameter int OH_FIRST = 1,
    parameter int OH_LAST  = 28
) (
    input  tdm_addr_t         addr,
    input  logic              live,
    input  logic [N_CHAN-1:0] chan_en,
    input  logic [N_CHAN-1:0] chan_data,
    input  logic              oh_data,
    output logic              sel_bit
);

    localparam logic [WORD_W-1:0] OH_LO = WORD_W'(OH_FIRST);
    localparam logic [WORD_W-1:0] OH_HI = WORD_W'(OH_LAST);

    logic [SLOTS-1:0] slot_bits;
    logic             oh_window;

    assign oh_window    = (addr.word >= OH_LO) && (addr.word <= OH_HI);
    assign slot_bits[0] = oh_window & oh_data;

    for (genvar g = 1; g < SLOTS; g++) begin : g_slot
        if (g <= N_CHAN) begin : g_used
            assign slot_bits[g] = chan_en[g-1] & chan_data[g-1];
        end else begin : g_spare
            assign slot_bits[g] = 1'b0;
        end
    end

    always_comb begin
        sel_bit = 1'b0;
        if (live) sel_bit = slot_bits[addr.slot];
    end

endmodule

// File: rtl/tdm_out_mux.sv
module tdm_out_mux
    import tdm_mux_pkg::*;
#(
    parameter int N_CHAN     = 15,
    parameter int PIPE_DEPTH = 3,
    parameter int OH_FIRST   = 1,
    parameter int OH_LAST    = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHAN-1:0] chan_en,
    input  logic [N_CHAN-1:0] chan_data,
    input  logic              oh_data,
    output logic              ser_out,
    output logic              ser_out_n
);

    localparam logic [WORD_W-1:0] OH_LO = WORD_W'(OH_FIRST);
    localparam logic [WORD_W-1:0] OH_HI = WORD_W'(OH_LAST);

    tdm_addr_t seq_addr;
    logic      seq_live;
    tdm_addr_t sel_addr;
    logic      sel_vld;
    logic      sel_bit;
    logic      sel_inv;
    logic      out_true_q;
    logic      out_comp_q;

    tdm_addr_seq #(
        .FILL_CYC (PIPE_DEPTH)
    ) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (seq_addr),
        .live  (seq_live)
    );

    tdm_addr_pipe #(
        .DEPTH (PIPE_DEPTH)
    ) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (seq_addr),
        .vld_in   (1'b1),
        .addr_out (sel_addr),
        .vld_out  (sel_vld)
    );

    tdm_slot_sel #(
        .N_CHAN   (N_CHAN),
        .OH_FIRST (OH_FIRST),
        .OH_LAST  (OH_LAST)
    ) i_sel (
        .addr      (sel_addr),
        .live      (seq_live),
        .chan_en   (chan_en),
        .chan_data (chan_data),
        .oh_data   (oh_data),
        .sel_bit   (sel_bit)
    );

    // Selected bit is inverted ahead of the reclocking stage.
    assign sel_inv = ~sel_bit;

    // Reclocking stage: a true register and a complementary register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_true_q <= 1'b0;
            out_comp_q <= 1'b1;
        end else begin
            out_true_q <= ~sel_inv;
            out_comp_q <= sel_inv;
        end
    end

    assign ser_out   = out_true_q;
    assign ser_out_n = out_comp_q;

    // Slots that can only carry 0: disabled channels and spare slots.
    logic [SLOTS-1:0] slot_used;
    assign slot_used[0] = 1'b1;
    for (genvar g = 1; g < SLOTS; g++) begin : g_used_map
        if (g <= N_CHAN) begin : g_ch
            assign slot_used[g] = chan_en[g-1];
        end else begin : g_none
            assign slot_used[g] = 1'b0;
        end
    end

    // R6: the two outputs are always complementary.
    p_compl_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out != ser_out_n);

    // R1: a blanked selector yields 0 on the next clock.
    p_fill_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_live |=> !ser_out);

    // R3: the sequencer goes live exactly when the address chain delivers valid addresses.
    p_pipe_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_live == sel_vld);

    // R4: slot 0 outside the overhead window carries 0.
    p_oh_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_live && sel_addr.slot == '0 &&
         (sel_addr.word < OH_LO || sel_addr.word > OH_HI)) |=> !ser_out);

    // R5: a disabled channel slot carries 0.
    p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_live && !slot_used[sel_addr.slot]) |=> !ser_out);

endmodule

// File: tb/test_tdm_out_mux.sv
module test_tdm_out_mux;

    localparam int N_CHAN      = 15;
    localparam int FRAME_SLOTS = 512;
    localparam int LAT         = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CHAN-1:0] chan_en = '0;
    logic [N_CHAN-1:0] chan_data = '0;
    logic              oh_data = 1'b0;
    logic              ser_out;
    logic              ser_out_n;

    int checks = 0;
    int errors = 0;
    int edges  = 0;

    always #10 clk = ~clk;

    tdm_out_mux i_tdm_out_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .chan_data (chan_data),
        .oh_data   (oh_data),
        .ser_out   (ser_out),
        .ser_out_n (ser_out_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b (edge %0d)", req, got, exp, edges);
        end
    endtask

    function automatic logic exp_bit(input int e);
        int idx, w, s;
        if (e < LAT) return 1'b0;
        idx = (e - LAT) % FRAME_SLOTS;
        w = idx / 16;
        s = idx % 16;
        if (s == 0) return (w >= 1 && w <= 28) ? oh_data : 1'b0;
        return chan_en[s-1] & chan_data[s-1];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R1", ser_out, 1'b0);
            check("R1", ser_out_n, 1'b1);
        end
        rst_n = 1'b1;
    endtask

    task automatic run_stream(input int n);
        for (int c = 0; c < n; c++) begin
            int    e;
            int    s;
            logic  x;
            string tag;
            @(negedge clk);
            e = edges;
            x = exp_bit(e);
            s = (e >= LAT) ? ((e - LAT) % 16) : 0;
            if (e < LAT)                     tag = "R1";
            else if (e - LAT >= FRAME_SLOTS) tag = "R7";
            else if (s == 0)                 tag = "R4";
            else if (!chan_en[s-1])          tag = "R5";
            else                             tag = "R2";
            check(tag, ser_out, x);
            check("R6", ser_out_n, ~x);
        end
    endtask

    task automatic t_reset();
        chan_en = '1; chan_data = '1; oh_data = 1'b1;
        do_reset();
        run_stream(3);
    endtask

    task automatic t_delay();
        chan_en = '1; chan_data = '1; oh_data = 1'b0;
        do_reset();
        run_stream(3);
        @(negedge clk);
        check("R3", ser_out, 1'b0);   // edge 4: word 0 slot 0
        @(negedge clk);
        check("R3", ser_out, 1'b1);   // edge 5: slot 1 (channel 1)
        check("R3", ser_out_n, 1'b0);
    endtask

    task automatic t_order(input logic [N_CHAN-1:0] data);
        chan_en = '1; chan_data = data; oh_data = 1'b0;
        do_reset();
        run_stream(60);
    endtask

    task automatic t_mask();
        chan_en = 15'h5555 & 15'h7fff; chan_data = '1; oh_data = 1'b1;
        do_reset();
        run_stream(60);
    endtask

    task automatic t_frame();
        chan_en = '0; chan_data = '1; oh_data = 1'b1;
        do_reset();
        run_stream(LAT - 1 + FRAME_SLOTS + 48);
    endtask

    task automatic t_mixed();
        chan_en = 15'h3bd7; chan_data = 15'h2a5c; oh_data = 1'b1;
        do_reset();
        run_stream(LAT - 1 + FRAME_SLOTS + 20);
    endtask

    initial begin
        t_reset();
        t_delay();
        t_order(15'h4c63);
        t_order(15'h0001);
        t_order(15'h4000);
        t_mask();
        t_frame();
        t_mixed();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule